// File: doc/BRIEF.md
# Decimal-Capable Add/Subtract Unit

This block adds with carry or subtracts with borrow on two packed operands of 4-bit digits, two digits by default. It works either in plain binary or in packed decimal (BCD). It returns the result together with negative, overflow, zero and carry flags. A done strobe marks completion. A binary operation finishes in the cycle after start. A decimal operation takes one more cycle, because the digit correction is done from registered operands. In decimal mode the negative, zero and overflow flags describe the corrected decimal result, not the intermediate binary sum.

The unit also holds the decimal-mode flag that selects between the two modes. The surrounding core can write the flag. A hardware reset clears it. An interrupt-entry pulse clears it too, but the pre-clear value is first copied into a separate output, so the status image that gets pushed keeps the old setting. The mode an operation uses is the flag value during its start cycle.

Top module: `decAddSubUnit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the result, all four flags, done, the decimal flag and the pushed copy read 0.
- R2: Binary add (opSub=0, decimal flag 0) gives result = (acc + oper + carryIn) mod 256. flagC=1 when the true sum exceeds 255. flagV=1 when the signed sum falls outside -128..127. flagN is result bit 7. flagZ=1 when the result is 0.
- R3: Binary subtract (opSub=1) gives acc - oper - (1 - carryIn) mod 256. flagC=1 means no borrow (true difference >= 0). flagV=1 when the signed difference falls outside -128..127. N and Z follow the result as in R2.
- R4: With the decimal flag 0, done is high for exactly one cycle, in the cycle after the start cycle. The outputs hold the new values in that same cycle.
- R5: Decimal add on valid BCD operands gives the BCD encoding of (a + b + carryIn) mod 100, with flagC=1 when the decimal sum is 100 or more.
- R6: Decimal subtract on valid BCD operands gives the BCD encoding of (a - b - (1 - carryIn)) mod 100, with flagC=1 when no borrow occurs.
- R7: In decimal mode, flagN is bit 7 of the corrected result and flagZ is 1 when the corrected result is 0. For an add, flagV is 1 when both operands have equal bit 7 and the result's bit 7 differs from it. For a subtract, flagV is 1 when the operands' bits 7 differ and the result's bit 7 differs from the accumulator's.
- R8: With the decimal flag 1, done is low in the cycle after start and high for exactly one cycle in the cycle after that.
- R9: A start asserted in the correction cycle of a decimal operation is ignored. It changes no output and produces no done.
- R10: Result and flags hold their values in every cycle that does not complete an operation.
- R11: decWrEn=1 loads decWrVal into the decimal flag at the next edge. The operation's mode is the flag value in its start cycle.
- R12: An intEntry pulse copies the current decimal flag to pushedDec and clears the decimal flag at the same edge. This takes priority over a simultaneous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Begin an operation with the present operands |
| opSub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| accIn | input | 8 | Accumulator operand |
| operIn | input | 8 | Second operand |
| carryIn | input | 1 | Carry in (for subtract, 1 = no borrow) |
| decWrEn | input | 1 | Write strobe for the decimal flag |
| decWrVal | input | 1 | Value written to the decimal flag |
| intEntry | input | 1 | Interrupt-entry pulse: save and clear the decimal flag |
| resultOut | output | 8 | Registered result |
| flagN | output | 1 | Negative flag |
| flagV | output | 1 | Overflow flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / no-borrow flag |
| doneOut | output | 1 | One-cycle completion strobe |
| decFlag | output | 1 | Current decimal-mode flag |
| pushedDec | output | 1 | Decimal flag value captured at the last interrupt entry |

## Verification
The hardest situation to reach is the correction cycle of a decimal operation coinciding with other events. These include a second start that must be dropped, and an interrupt entry landing in the same cycle as a start, where the operation must still run in decimal mode while the flag clears. The stimulus reaches these by holding start high across two consecutive cycles after setting the flag, and by pulsing intEntry together with start. Apart from that, every valid BCD operand pair is swept in both directions with alternating carry. A spread of binary pairs across all accumulator values is also swept, and every expected value is computed with integer arithmetic on decimal or signed values.

// File: rtl/decAluPkg.sv
package decAluPkg;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic capture;    // latch operands for the decimal correction cycle
    logic finishBin;  // commit the binary result computed from live inputs
    logic finishDec;  // commit the corrected decimal result
  } aluStrobe_t;

endpackage

// File: rtl/bcdDigitFix.sv
module bcdDigitFix (
  input  logic [3:0] aDig,
  input  logic [3:0] bDig,
  input  logic       carryIn,
  input  logic       isSub,
  output logic [3:0] digOut,
  output logic       carryOut
);

  logic [4:0] rawSum;
  logic [4:0] rawDiff;
  logic [4:0] fixedSum;
  logic       adjAdd;
  logic       borrow;

  always_comb begin
    rawSum   = {1'b0, aDig} + {1'b0, bDig} + {4'b0000, carryIn};
    adjAdd   = (rawSum > 5'd9);
    fixedSum = rawSum + (adjAdd ? 5'd6 : 5'd0);
    rawDiff  = {1'b0, aDig} - {1'b0, bDig} - {4'b0000, ~carryIn};
    borrow   = rawDiff[4];
    if (isSub) begin
      digOut   = rawDiff[3:0] - (borrow ? 4'd6 : 4'd0);
      carryOut = ~borrow;
    end else begin
      digOut   = fixedSum[3:0];
      carryOut = adjAdd;
    end
  end

endmodule

// File: rtl/bcdAluPath.sv
module bcdAluPath
  import decAluPkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  aluStrobe_t            strobeIn,
  input  logic [4*DIGITS-1:0]   accIn,
  input  logic [4*DIGITS-1:0]   operIn,
  input  logic                  carryIn,
  input  logic                  opSub,
  output logic [4*DIGITS-1:0]   resultOut,
  output logic                  flagN,
  output logic                  flagV,
  output logic                  flagZ,
  output logic                  flagC
);

  localparam int W   = 4 * DIGITS;
  localparam int MSB = W - 1;

  // binary path straight from the live inputs
  logic [W-1:0] operEff;
  logic [W:0]   binSum;
  logic [W-1:0] binRes;
  logic         binC;
  logic         binV;

  always_comb begin
    operEff = opSub ? ~operIn : operIn;
    binSum  = {1'b0, accIn} + {1'b0, operEff} + {{W{1'b0}}, carryIn};
    binRes  = binSum[W-1:0];
    binC    = binSum[W];
    binV    = (accIn[MSB] == operEff[MSB]) && (binRes[MSB] != accIn[MSB]);
  end

  // operand stage for the decimal correction cycle
  logic [W-1:0] stA;
  logic [W-1:0] stB;
  logic         stC;
  logic         stSub;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stA   <= '0;
      stB   <= '0;
      stC   <= 1'b0;
      stSub <= 1'b0;
    end else if (strobeIn.capture) begin
      stA   <= accIn;
      stB   <= operIn;
      stC   <= carryIn;
      stSub <= opSub;
    end
  end

  // digit-serial correction chain
  logic [DIGITS:0] chainC;
  logic [W-1:0]    decRes;
  logic [W-1:0]    stBEff;
  logic            decV;

  assign chainC[0] = stC;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    bcdDigitFix uFix (
      .aDig    (stA[4*g +: 4]),
      .bDig    (stB[4*g +: 4]),
      .carryIn (chainC[g]),
      .isSub   (stSub),
      .digOut  (decRes[4*g +: 4]),
      .carryOut(chainC[g+1])
    );
  end

  always_comb begin
    stBEff = stSub ? ~stB : stB;
    decV   = (stA[MSB] == stBEff[MSB]) && (decRes[MSB] != stA[MSB]);
  end

  // committed outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      flagN     <= 1'b0;
      flagV     <= 1'b0;
      flagZ     <= 1'b0;
      flagC     <= 1'b0;
    end else if (strobeIn.finishDec) begin
      resultOut <= decRes;
      flagN     <= decRes[MSB];
      flagV     <= decV;
      flagZ     <= (decRes == '0);
      flagC     <= chainC[DIGITS];
    end else if (strobeIn.finishBin) begin
      resultOut <= binRes;
      flagN     <= binRes[MSB];
      flagV     <= binV;
      flagZ     <= (binRes == '0);
      flagC     <= binC;
    end
  end

  // R10: nothing moves without a commit strobe
  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !(strobeIn.finishBin || strobeIn.finishDec) |=>
      ($stable(resultOut) && $stable(flagN) && $stable(flagV) && $stable(flagZ) && $stable(flagC)));

  // R7: decimal N and Z describe the corrected result
  a_r7_dec_nz: assert property (@(posedge clk) disable iff (!rstN)
    strobeIn.finishDec |=> ((flagZ == (resultOut == '0)) && (flagN == resultOut[MSB])));

endmodule

// File: rtl/bcdAluCtl.sv
module bcdAluCtl
  import decAluPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       decWrEn,
  input  logic       decWrVal,
  input  logic       intEntry,
  output aluStrobe_t strobeOut,
  output logic       doneOut,
  output logic       decFlagOut,
  output logic       pushDecOut
);

  typedef enum logic {PH_IDLE, PH_FIX} phase_t;

  phase_t phase;
  phase_t phaseNext;
  logic   accept;

  always_comb begin
    accept    = startIn && (phase == PH_IDLE);
    strobeOut = '0;
    phaseNext = phase;
    if (phase == PH_FIX) begin
      strobeOut.finishDec = 1'b1;
      phaseNext           = PH_IDLE;
    end else if (accept) begin
      if (decFlagOut) begin
        strobeOut.capture = 1'b1;
        phaseNext         = PH_FIX;
      end else begin
        strobeOut.finishBin = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      doneOut <= 1'b0;
    end else begin
      phase   <= phaseNext;
      doneOut <= strobeOut.finishBin || strobeOut.finishDec;
    end
  end

  // decimal-mode flag: interrupt entry saves then clears, beating a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decFlagOut <= 1'b0;
      pushDecOut <= 1'b0;
    end else if (intEntry) begin
      pushDecOut <= decFlagOut;
      decFlagOut <= 1'b0;
    end else if (decWrEn) begin
      decFlagOut <= decWrVal;
    end
  end

  a_r4_bin_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !decFlagOut) |=> doneOut);

  a_r8_dec_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    (accept && decFlagOut) |=> !doneOut ##1 doneOut);

  a_r9_busy_start_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FIX && startIn) |=> (phase == PH_IDLE));

  a_r12_push_then_clear: assert property (@(posedge clk) disable iff (!rstN)
    intEntry |=> (!decFlagOut && (pushDecOut == $past(decFlagOut))));

  a_r11_flag_write: assert property (@(posedge clk) disable iff (!rstN)
    (decWrEn && !intEntry) |=> (decFlagOut == $past(decWrVal)));

endmodule

// File: rtl/decAddSubUnit.sv
module decAddSubUnit
  import decAluPkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic                opSub,
  input  logic [4*DIGITS-1:0] accIn,
  input  logic [4*DIGITS-1:0] operIn,
  input  logic                carryIn,
  input  logic                decWrEn,
  input  logic                decWrVal,
  input  logic                intEntry,
  output logic [4*DIGITS-1:0] resultOut,
  output logic                flagN,
  output logic                flagV,
  output logic                flagZ,
  output logic                flagC,
  output logic                doneOut,
  output logic                decFlag,
  output logic                pushedDec
);

  aluStrobe_t strobe;

  bcdAluCtl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .decWrEn   (decWrEn),
    .decWrVal  (decWrVal),
    .intEntry  (intEntry),
    .strobeOut (strobe),
    .doneOut   (doneOut),
    .decFlagOut(decFlag),
    .pushDecOut(pushedDec)
  );

  bcdAluPath #(.DIGITS(DIGITS)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobeIn (strobe),
    .accIn    (accIn),
    .operIn   (operIn),
    .carryIn  (carryIn),
    .opSub    (opSub),
    .resultOut(resultOut),
    .flagN    (flagN),
    .flagV    (flagV),
    .flagZ    (flagZ),
    .flagC    (flagC)
  );

endmodule

// File: tb/tb_decAddSubUnit.sv
module tb_decAddSubUnit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic       opSub = 1'b0;
  logic [7:0] accIn = '0;
  logic [7:0] operIn = '0;
  logic       carryIn = 1'b0;
  logic       decWrEn = 1'b0;
  logic       decWrVal = 1'b0;
  logic       intEntry = 1'b0;
  logic [7:0] resultOut;
  logic       flagN, flagV, flagZ, flagC, doneOut, decFlag, pushedDec;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  decAddSubUnit dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opSub(opSub),
    .accIn(accIn), .operIn(operIn), .carryIn(carryIn),
    .decWrEn(decWrEn), .decWrVal(decWrVal), .intEntry(intEntry),
    .resultOut(resultOut), .flagN(flagN), .flagV(flagV), .flagZ(flagZ),
    .flagC(flagC), .doneOut(doneOut), .decFlag(decFlag), .pushedDec(pushedDec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int flagsNow();
    return {28'd0, flagN, flagV, flagZ, flagC};
  endfunction

  function automatic int sgn8(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic int bcdVal(input int x);
    return (x >> 4) * 10 + (x & 15);
  endfunction

  task automatic expBin(input int a, input int b, input int c, input int sub,
                        output int res, output int flg);
    int t, sv, cf, vf;
    if (sub != 0) begin
      t  = a - b - (1 - c);
      sv = sgn8(a) - sgn8(b) - (1 - c);
      cf = (t >= 0) ? 1 : 0;
    end else begin
      t  = a + b + c;
      sv = sgn8(a) + sgn8(b) + c;
      cf = (t > 255) ? 1 : 0;
    end
    res = (t + 512) % 256;
    vf  = (sv > 127 || sv < -128) ? 1 : 0;
    flg = ((res >> 7) << 3) | (vf << 2) | (((res == 0) ? 1 : 0) << 1) | cf;
  endtask

  task automatic expDec(input int a, input int b, input int c, input int sub,
                        output int res, output int cf, output int nvz);
    int t, r, sa, sb, sr, vf;
    if (sub != 0) begin
      t  = bcdVal(a) - bcdVal(b) - (1 - c);
      cf = (t >= 0) ? 1 : 0;
    end else begin
      t  = bcdVal(a) + bcdVal(b) + c;
      cf = (t >= 100) ? 1 : 0;
    end
    r   = (t + 200) % 100;
    res = ((r / 10) << 4) | (r % 10);
    sa = a >> 7; sb = b >> 7; sr = res >> 7;
    if (sub != 0) vf = (sa != sb && sr != sa) ? 1 : 0;
    else          vf = (sa == sb && sr != sa) ? 1 : 0;
    nvz = (sr << 2) | (vf << 1) | ((res == 0) ? 1 : 0);
  endtask

  task automatic drive(input int a, input int b, input int c, input int sub);
    @(negedge clk);
    accIn = a[7:0]; operIn = b[7:0]; carryIn = c[0]; opSub = sub[0];
    startIn = 1'b1;
  endtask

  task automatic binOp(input int a, input int b, input int c, input int sub, input string req);
    int er, ef;
    drive(a, b, c, sub);
    @(negedge clk);
    startIn = 1'b0;
    expBin(a, b, c, sub, er, ef);
    chk({req, " result"}, int'(resultOut), er);
    chk({req, " flags NVZC"}, flagsNow(), ef);
    chk("R4 done after one cycle", int'(doneOut), 1);
  endtask

  task automatic decOp(input int a, input int b, input int c, input int sub, input string req);
    int er, ec, env;
    drive(a, b, c, sub);
    @(negedge clk);
    startIn = 1'b0;
    chk("R8 no done in correction cycle", int'(doneOut), 0);
    @(negedge clk);
    expDec(a, b, c, sub, er, ec, env);
    chk({req, " result"}, int'(resultOut), er);
    chk({req, " carry"}, int'(flagC), ec);
    chk("R7 decimal NVZ", {29'd0, flagN, flagV, flagZ}, env);
    chk("R8 done after two cycles", int'(doneOut), 1);
  endtask

  task automatic setDec(input bit v);
    @(negedge clk);
    decWrEn = 1'b1; decWrVal = v;
    @(negedge clk);
    decWrEn = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int keepR, keepF;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 result in reset", int'(resultOut), 0);
    chk("R1 done in reset", int'(doneOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 result", int'(resultOut), 0);
    chk("R1 flags", flagsNow(), 0);
    chk("R1 done", int'(doneOut), 0);
    chk("R1 decimal flag", int'(decFlag), 0);
    chk("R1 pushed copy", int'(pushedDec), 0);

    // R4 single-cycle done pulse and R10 hold
    binOp(8'h7F, 8'h01, 0, 0, "R2");
    @(negedge clk);
    chk("R4 done one cycle only", int'(doneOut), 0);
    keepR = int'(resultOut); keepF = flagsNow();
    accIn = 8'h00; operIn = 8'h00; opSub = 1'b1; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 result held", int'(resultOut), keepR);
    chk("R10 flags held", flagsNow(), keepF);

    // R2/R3 binary sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        int mode = (a + b) & 3;
        binOp(a, b, mode & 1, mode >> 1, (mode >> 1) != 0 ? "R3" : "R2");
      end
    end

    // R11 flag write selects decimal mode
    setDec(1'b1);
    chk("R11 decimal flag written", int'(decFlag), 1);

    // R5/R6/R7 decimal sweep over all valid BCD pairs
    for (int i = 0; i < 100; i++) begin
      for (int j = 0; j < 100; j++) begin
        int a = ((i / 10) << 4) | (i % 10);
        int b = ((j / 10) << 4) | (j % 10);
        decOp(a, b, (i + j) & 1, 0, "R5");
        decOp(a, b, (i + j + 1) & 1, 1, "R6");
      end
    end

    // R9 start during correction cycle is dropped
    drive(8'h45, 8'h38, 0, 0);
    @(negedge clk);
    accIn = 8'h11; operIn = 8'h11;
    @(negedge clk);
    startIn = 1'b0;
    chk("R9 first result kept", int'(resultOut), 8'h83);
    chk("R9 done for first op", int'(doneOut), 1);
    @(negedge clk);
    chk("R9 no second done", int'(doneOut), 0);
    chk("R9 result unchanged", int'(resultOut), 8'h83);

    // R12 interrupt entry with start in the same cycle (mode from old flag, R11)
    @(negedge clk);
    accIn = 8'h09; operIn = 8'h01; carryIn = 1'b0; opSub = 1'b0;
    startIn = 1'b1; intEntry = 1'b1;
    @(negedge clk);
    startIn = 1'b0; intEntry = 1'b0;
    chk("R12 flag cleared", int'(decFlag), 0);
    chk("R12 old flag pushed", int'(pushedDec), 1);
    chk("R11 mode from start cycle, no early done", int'(doneOut), 0);
    @(negedge clk);
    chk("R11 decimal result", int'(resultOut), 8'h10);
    chk("R11 decimal done", int'(doneOut), 1);

    // R12 priority over a simultaneous write, and pushed copy of a clear flag
    @(negedge clk);
    intEntry = 1'b1; decWrEn = 1'b1; decWrVal = 1'b1;
    @(negedge clk);
    intEntry = 1'b0; decWrEn = 1'b0;
    chk("R12 clear beats write", int'(decFlag), 0);
    chk("R12 pushed old zero", int'(pushedDec), 0);

    // R4 binary again after clearing: 0x09+0x01 in binary
    binOp(8'h09, 8'h01, 0, 0, "R4 binary mode");

    // R1 reset clears a set decimal flag
    setDec(1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset clears decimal flag", int'(decFlag), 0);
    chk("R1 reset clears result", int'(resultOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule